// File: doc/BRIEF.md
# Thread-Priority Reschedule Interrupt Generator

This block helps an operating-system scheduler keep the best work running on a multithreaded core. Software loads a best-waiting priority: the priority of the most urgent task that is ready but has no hardware thread. Software also sets a scheduler enable bit. On every cycle the block compares the current priority of each hardware thread against that value. When a thread is running something less urgent than the waiting task, the block raises a reschedule interrupt.

The interrupt goes to one thread only: the eligible thread that is running the least urgent work. The output is a one-cycle pulse together with a one-hot thread select. In the cycle it fires, the block loads the best-waiting value back to its all-ones idle code, so a single waiting task raises one interrupt. Software programs both registers through a small write port. A software write and a hardware reload that land in the same cycle are resolved in favour of the write.

Top module: `resched_irq_gen`

## Requirements
- R1: After reset the enable bit is 0, the best-waiting value is 0x1ff, `resched_irq` is 0 and `target_thread` is all zeros. While no write has been made, a thread priority of 0x1fe therefore never fires, even when the enable bit is later set.
- R2: While the enable bit is 0, `resched_irq` stays 0 whatever the thread priorities and eligibility mask are.
- R3: While enabled, if any thread's priority (eligible or not) is strictly greater than the best-waiting value and at least one thread is eligible, `resched_irq` is 1 in the cycle after those inputs are present.
- R4: A thread priority equal to the best-waiting value does not fire, because a numerically larger value is the worse priority.
- R5: When the interrupt fires, `target_thread` is one-hot and selects the eligible thread with the numerically largest priority. Thread i is `thread_prio[i*9 +: 9]` and `thread_eligible[i]`.
- R6: When several eligible threads share the largest priority, the thread with the lowest index is selected.
- R7: With an all-zero eligibility mask nothing fires, and the best-waiting value stays as it is.
- R8: The cycle that fires reloads the best-waiting value with 0x1ff. The pulse therefore lasts one cycle, even when the thread priorities stay unchanged.
- R9: A write to the best-waiting register made in the firing cycle overrides the 0x1ff reload.
- R10: A write with `wr_addr`=0 sets the enable bit to `wr_data[0]`. A write with `wr_addr`=1 loads `wr_data[8:0]` into the best-waiting register. Whenever `resched_irq` is 0, `target_thread` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: enable bit, 1: best-waiting priority |
| wr_data | input | 9 | Write data |
| thread_prio | input | 72 | Packed current priority, 9 bits per thread |
| thread_eligible | input | 8 | Per-thread eligibility to take the interrupt |
| resched_irq | output | 1 | One-cycle reschedule interrupt pulse |
| target_thread | output | 8 | One-hot selected thread, zero when idle |

## Verification
The bench builds the block with its defaults: eight threads and 9-bit priorities. The full 0x000 to 0x1ff range is therefore available, including the 0x1fe case just below the idle code. With eight threads, ties can be spread across both low and high indices. Ineligible threads can also carry the worst priority while the target falls on a different thread.

// File: rtl/resched_pkg.sv
package resched_pkg;
    localparam int unsigned DEF_THREADS = 8;
    localparam int unsigned DEF_PRIO_W  = 9;

    typedef enum logic {
        SEL_CTRL     = 1'b0,
        SEL_BESTWAIT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/resched_cfg.sv
module resched_cfg #(
    parameter int unsigned PRIO_W = resched_pkg::DEF_PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [PRIO_W-1:0] wr_data,
    input  logic              fire,
    output logic              enable,
    output logic [PRIO_W-1:0] best_wait
);
    import resched_pkg::*;

    localparam logic [PRIO_W-1:0] IDLE_CODE = {PRIO_W{1'b1}};

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] bw;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_bw;

    always_comb begin
        cfg_d = cfg_q;
        wr_bw = wr_en && (reg_sel_e'(wr_addr) == SEL_BESTWAIT);
        if (fire) begin
            cfg_d.bw = IDLE_CODE;
        end
        if (wr_bw) begin
            cfg_d.bw = wr_data;
        end
        if (wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL)) begin
            cfg_d.en = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{en: 1'b0, bw: IDLE_CODE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable    = cfg_q.en;
    assign best_wait = cfg_q.bw;

    p_reload_on_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_bw) |=> (best_wait == IDLE_CODE));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bw |=> (best_wait == $past(wr_data)));
endmodule

// File: rtl/resched_detect.sv
module resched_detect #(
    parameter int unsigned THREADS = resched_pkg::DEF_THREADS,
    parameter int unsigned PRIO_W  = resched_pkg::DEF_PRIO_W
) (
    input  logic [THREADS*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         best_wait,
    output logic                      any_worse
);
    logic [THREADS-1:0] worse;

    for (genvar i = 0; i < THREADS; i++) begin : g_cmp
        assign worse[i] = prio[i*PRIO_W +: PRIO_W] > best_wait;
    end

    assign any_worse = |worse;
endmodule

// File: rtl/resched_steer.sv
module resched_steer #(
    parameter int unsigned THREADS = resched_pkg::DEF_THREADS,
    parameter int unsigned PRIO_W  = resched_pkg::DEF_PRIO_W
) (
    input  logic [THREADS*PRIO_W-1:0] prio,
    input  logic [THREADS-1:0]        eligible,
    output logic [THREADS-1:0]        pick,
    output logic                      any_eligible
);
    logic [PRIO_W-1:0] worst_val;
    logic              found;

    always_comb begin
        pick      = '0;
        worst_val = '0;
        found     = 1'b0;
        for (int i = 0; i < THREADS; i++) begin
            if (eligible[i] && (!found || (prio[i*PRIO_W +: PRIO_W] > worst_val))) begin
                pick      = '0;
                pick[i]   = 1'b1;
                worst_val = prio[i*PRIO_W +: PRIO_W];
                found     = 1'b1;
            end
        end
        any_eligible = found;
    end
endmodule

// File: rtl/resched_irq_gen.sv
module resched_irq_gen #(
    parameter int unsigned THREADS = resched_pkg::DEF_THREADS,
    parameter int unsigned PRIO_W  = resched_pkg::DEF_PRIO_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_addr,
    input  logic [PRIO_W-1:0]         wr_data,
    input  logic [THREADS*PRIO_W-1:0] thread_prio,
    input  logic [THREADS-1:0]        thread_eligible,
    output logic                      resched_irq,
    output logic [THREADS-1:0]        target_thread
);
    typedef struct packed {
        logic               irq;
        logic [THREADS-1:0] tgt;
    } out_t;

    out_t out_d, out_q;

    logic               en;
    logic [PRIO_W-1:0]  bw;
    logic               any_worse;
    logic [THREADS-1:0] pick;
    logic               any_elig;
    logic               fire;

    resched_cfg #(.PRIO_W(PRIO_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fire      (fire),
        .enable    (en),
        .best_wait (bw)
    );

    resched_detect #(.THREADS(THREADS), .PRIO_W(PRIO_W)) u_detect (
        .prio      (thread_prio),
        .best_wait (bw),
        .any_worse (any_worse)
    );

    resched_steer #(.THREADS(THREADS), .PRIO_W(PRIO_W)) u_steer (
        .prio         (thread_prio),
        .eligible     (thread_eligible),
        .pick         (pick),
        .any_eligible (any_elig)
    );

    always_comb begin
        fire    = en && any_worse && any_elig;
        out_d   = '0;
        if (fire) begin
            out_d.irq = 1'b1;
            out_d.tgt = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign resched_irq   = out_q.irq;
    assign target_thread = out_q.tgt;

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !resched_irq);

    p_need_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_eligible == '0) |=> !resched_irq);

    p_onehot_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resched_irq |-> ($countones(target_thread) == 1));

    p_target_was_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((target_thread & ~$past(thread_eligible)) == '0));

    p_idle_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !resched_irq |-> (target_thread == '0));
endmodule

// File: tb/resched_irq_gen_test.sv
module resched_irq_gen_test;
    localparam int N = 8;
    localparam int W = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           wr_addr = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic [W-1:0]   prio_arr [N];
    logic [N*W-1:0] thread_prio;
    logic [N-1:0]   thread_eligible = '1;
    logic           resched_irq;
    logic [N-1:0]   target_thread;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) thread_prio[i*W +: W] = prio_arr[i];
    end

    resched_irq_gen uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .thread_prio     (thread_prio),
        .thread_eligible (thread_eligible),
        .resched_irq     (resched_irq),
        .target_thread   (target_thread)
    );

    task automatic check(input logic exp_irq, input logic [N-1:0] exp_tgt, input string req);
        tests++;
        if (resched_irq !== exp_irq || target_thread !== exp_tgt) begin
            fails++;
            $display("FAIL %s: irq=%0b tgt=%b expected irq=%0b tgt=%b",
                     req, resched_irq, target_thread, exp_irq, exp_tgt);
        end
    endtask

    task automatic clear_prios();
        for (int i = 0; i < N; i++) prio_arr[i] = '0;
    endtask

    task automatic reg_write(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check(1'b0, '0, "R1 reset outputs");
        reg_write(1'b0, 9'h001);
        for (int i = 0; i < N; i++) prio_arr[i] = 9'h1fe;
        @(negedge clk); check(1'b0, '0, "R1 idle code blocks 0x1fe");
        @(negedge clk); check(1'b0, '0, "R1 idle code blocks 0x1fe");
        clear_prios();
    endtask

    task automatic t_enable_gate();
        reg_write(1'b0, 9'h1fe);
        reg_write(1'b1, 9'd5);
        prio_arr[3] = 9'd100;
        @(negedge clk); check(1'b0, '0, "R2 disabled");
        @(negedge clk); check(1'b0, '0, "R2 disabled");
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 9'h001;
        @(negedge clk); wr_en = 1'b0;
        check(1'b0, '0, "R10 enable write lands");
        @(negedge clk); check(1'b1, 8'b0000_1000, "R3 fires after enable");
        clear_prios();
        @(negedge clk);
    endtask

    task automatic t_basic();
        reg_write(1'b1, 9'd50);
        prio_arr = '{9'd10, 9'd20, 9'd60, 9'd5, 9'd7, 9'd200, 9'd3, 9'd0};
        @(negedge clk); check(1'b1, 8'b0010_0000, "R3 R5 worst eligible");
        @(negedge clk); check(1'b0, '0, "R8 single pulse");
        prio_arr[0] = 9'd300;
        @(negedge clk); check(1'b0, '0, "R8 reloaded to 0x1ff");
        clear_prios();
    endtask

    task automatic t_strict();
        reg_write(1'b1, 9'd100);
        for (int i = 0; i < N; i++) prio_arr[i] = 9'd100;
        @(negedge clk); check(1'b0, '0, "R4 equal no fire");
        @(negedge clk); check(1'b0, '0, "R4 equal no fire");
        prio_arr[4] = 9'd101;
        @(negedge clk); check(1'b1, 8'b0001_0000, "R4 one above fires");
        clear_prios();
        @(negedge clk);
    endtask

    task automatic t_tie();
        reg_write(1'b1, 9'd10);
        prio_arr[1] = 9'd80; prio_arr[3] = 9'd80; prio_arr[6] = 9'd80;
        @(negedge clk); check(1'b1, 8'b0000_0010, "R6 tie lowest index");
        clear_prios();
        thread_eligible = 8'b1111_1101;
        reg_write(1'b1, 9'd10);
        prio_arr[1] = 9'd80; prio_arr[3] = 9'd80; prio_arr[6] = 9'd80;
        @(negedge clk); check(1'b1, 8'b0000_1000, "R6 tie next eligible");
        clear_prios();
        thread_eligible = '1;
        @(negedge clk);
    endtask

    task automatic t_ineligible_worst();
        reg_write(1'b1, 9'd10);
        thread_eligible = 8'b0100_0100;
        prio_arr[0] = 9'd400; prio_arr[2] = 9'd3; prio_arr[6] = 9'd7;
        @(negedge clk); check(1'b1, 8'b0100_0000, "R3 R5 steer past ineligible");
        clear_prios();
        thread_eligible = '1;
        @(negedge clk);
    endtask

    task automatic t_no_eligible();
        reg_write(1'b1, 9'd10);
        thread_eligible = '0;
        prio_arr[4] = 9'd50;
        @(negedge clk); check(1'b0, '0, "R7 no eligible");
        @(negedge clk); check(1'b0, '0, "R7 no eligible");
        @(negedge clk); check(1'b0, '0, "R7 no eligible");
        thread_eligible = 8'b0001_0000;
        @(negedge clk); check(1'b1, 8'b0001_0000, "R7 value kept");
        clear_prios();
        thread_eligible = '1;
        @(negedge clk);
    endtask

    task automatic t_collision();
        reg_write(1'b1, 9'd10);
        prio_arr[2] = 9'd300;
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 9'd200;
        @(negedge clk);
        wr_en = 1'b0;
        check(1'b1, 8'b0000_0100, "R9 fire with write");
        @(negedge clk); check(1'b1, 8'b0000_0100, "R9 write beat reload");
        @(negedge clk); check(1'b0, '0, "R8 reload after second fire");
        clear_prios();
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: irq=%0b expected completion", resched_irq);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_prios();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_basic();
        t_strict();
        t_tie();
        t_ineligible_worst();
        t_no_eligible();
        t_collision();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule